// File: doc/BRIEF.md
# Eight-Instruction Stack Machine Core

A small multi-cycle processor with no general-purpose registers: every operand lives on an internal word stack. The core has three local stores of 128 bytes each. There is a byte-addressed program store of 128 one-byte instructions. There is a data store of 32 words and a stack of 32 words, both addressed in 4-byte units. Each instruction byte carries a 3-bit opcode in bits [7:5] and a 5-bit operand in bits [4:0].

After reset the core sits in load mode. In that mode a loader port writes program bytes into the program store and nothing executes. A high `run` leaves load mode. The core then steps each instruction through fetch, decode and execute, one cycle each. The stack starts empty and grows toward lower slots. A debug port reads any data word at any time. An attempt to push onto a full stack, or to consume more words than the stack holds, stops the core and raises a sticky `fault`.

Top module: `stk8_core`

## Requirements
- R1: After reset `busy` and `fault` are low, every data word reads 0 on the debug port, the stack is empty and the program counter is 0.
- R2: While in load mode, `ld_we` writes `ld_byte` to program address `ld_addr`, no instruction executes and `busy` stays low; a high `run` starts execution at address 0 and raises `busy`.
- R3: Opcodes 000, 001 and 010 take the top word A and the word below it B and replace B with A+B, A−B or ~(A&B) respectively, leaving one word fewer on the stack.
- R4: Opcode 011 pushes a copy of data word `operand`; opcode 100 removes the top word and stores it to data word `operand`.
- R5: Opcode 101 pushes the 5-bit operand zero-extended to a full word.
- R6: Opcode 110 leaves the stack unchanged; when the top word is zero the next instruction is at (own address + operand) modulo 128, otherwise at the following address.
- R7: Opcode 111 continues at the address given by the low 7 bits of the top word and removes that word.
- R8: A push (011 or 101) with 32 words already on the stack raises `fault` and changes no data word.
- R9: An instruction needing more words than the stack holds (two for 000–010, one for 100, 110 and 111) raises `fault` and changes no data word.
- R10: `fault` stays high until reset, `busy` is low whenever `fault` is high, and no further instruction executes.
- R11: Every instruction passes through fetch, decode and execute on three successive cycles, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Program write strobe, honoured only in load mode |
| ld_addr | input | 7 | Program byte address for a write |
| ld_byte | input | 8 | Program byte to write |
| run | input | 1 | Leave load mode and start execution |
| dbg_addr | input | 5 | Data word index to read |
| dbg_word | output | 32 | Data word at `dbg_addr` |
| busy | output | 1 | Core is executing |
| fault | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The arithmetic programs use operand pairs whose results differ under every wrong operand order: a subtraction that goes negative tells A−B from B−A, and the NAND inputs are chosen so AND, OR and NAND all give distinct words. The branch programs place distinctive stores on both the taken and skipped paths, and follow each branch with an instruction that underflows only if the branch wrongly popped. The indirect jump target is formed with all high bits set, so the 7-bit mask is what lands it inside the program. Fault programs store a marker before the failing instruction so an unwanted memory write or a missed stop shows up in a data word.

// File: rtl/stk8_core.sv
module stk8_core #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [6:0]        ld_addr,
  input  logic [7:0]        ld_byte,
  input  logic              run,
  input  logic [4:0]        dbg_addr,
  output logic [WORD_W-1:0] dbg_word,
  output logic              busy,
  output logic              fault
);
  localparam int REGION_BYTES = 128;
  localparam int CODE_AW      = $clog2(REGION_BYTES);
  localparam int SLOTS        = REGION_BYTES / 4;
  localparam int SLOT_AW      = $clog2(SLOTS);
  localparam int SP_W         = SLOT_AW + 1;
  localparam int OPND_W       = 5;

  typedef enum logic [2:0] {S_LOAD, S_FETCH, S_DECODE, S_EXEC, S_FAULT} state_t;
  typedef enum logic [2:0] {OP_ADD, OP_SUB, OP_NAND, OP_PUSH,
                            OP_POP, OP_PUSHC, OP_JZ, OP_JA} op_t;

  logic [7:0]        code_mem [REGION_BYTES];
  logic [WORD_W-1:0] data_mem [SLOTS];
  logic [WORD_W-1:0] stk_mem  [SLOTS];

  state_t             state;
  logic [CODE_AW-1:0] pc;
  logic [7:0]         ir;
  op_t                op;
  logic [OPND_W-1:0]  opnd;
  logic [SP_W-1:0]    sp;

  logic [SLOT_AW-1:0] top_idx, nxt_idx, new_idx;
  logic [WORD_W-1:0]  top_w, nxt_w, alu_w;
  logic               empty, short2, full, bad;

  assign top_idx = SLOT_AW'(sp);
  assign nxt_idx = SLOT_AW'(sp + SP_W'(1));
  assign new_idx = SLOT_AW'(sp - SP_W'(1));
  assign top_w   = stk_mem[top_idx];
  assign nxt_w   = stk_mem[nxt_idx];

  assign empty  = (sp == SP_W'(SLOTS));
  assign short2 = (sp >= SP_W'(SLOTS - 1));
  assign full   = (sp == '0);

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_NAND: bad = short2;
      OP_PUSH, OP_PUSHC:       bad = full;
      default:                 bad = empty;
    endcase
  end

  always_comb begin
    case (op)
      OP_ADD:  alu_w = top_w + nxt_w;
      OP_SUB:  alu_w = top_w - nxt_w;
      default: alu_w = ~(top_w & nxt_w);
    endcase
  end

  assign dbg_word = data_mem[dbg_addr];
  assign busy     = (state == S_FETCH) || (state == S_DECODE) || (state == S_EXEC);

  always_ff @(posedge clk) begin
    if (state == S_LOAD && ld_we) code_mem[ld_addr] <= ld_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_LOAD;
      pc    <= '0;
      ir    <= '0;
      op    <= OP_ADD;
      opnd  <= '0;
      sp    <= SP_W'(SLOTS);
      fault <= 1'b0;
      for (int i = 0; i < SLOTS; i++) data_mem[i] <= '0;
    end else begin
      case (state)
        S_LOAD:   if (run) state <= S_FETCH;
        S_FETCH: begin
          ir    <= code_mem[pc];
          pc    <= pc + CODE_AW'(1);
          state <= S_DECODE;
        end
        S_DECODE: begin
          op    <= op_t'(ir[7:5]);
          opnd  <= ir[OPND_W-1:0];
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (bad) begin
            fault <= 1'b1;
            state <= S_FAULT;
          end else begin
            state <= S_FETCH;
            case (op)
              OP_ADD, OP_SUB, OP_NAND: begin
                stk_mem[nxt_idx] <= alu_w;
                sp <= sp + SP_W'(1);
              end
              OP_PUSH: begin
                stk_mem[new_idx] <= data_mem[opnd];
                sp <= sp - SP_W'(1);
              end
              OP_POP: begin
                data_mem[opnd] <= top_w;
                sp <= sp + SP_W'(1);
              end
              OP_PUSHC: begin
                stk_mem[new_idx] <= {{(WORD_W-OPND_W){1'b0}}, opnd};
                sp <= sp - SP_W'(1);
              end
              OP_JZ: begin
                if (top_w == '0) pc <= pc + CODE_AW'(opnd) - CODE_AW'(1);
              end
              default: begin
                pc <= top_w[CODE_AW-1:0];
                sp <= sp + SP_W'(1);
              end
            endcase
          end
        end
        default: state <= S_FAULT;
      endcase
    end
  end
endmodule

// File: rtl/stk8_core_chk.sv
module stk8_core_chk #(
  parameter int SLOTS = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     fault,
  input logic [2:0]               state,
  input logic [$clog2(SLOTS):0]   sp
);
  localparam logic [2:0] LOAD = 3'd0, FETCH = 3'd1, DECODE = 3'd2, EXEC = 3'd3, HALT = 3'd4;

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  // R10
  fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !busy);

  // R10
  fault_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> $stable(sp));

  // R11
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FETCH) |=> (state == DECODE));

  // R11
  decode_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DECODE) |=> (state == EXEC));

  // R11
  exec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == EXEC) |=> (state == FETCH || state == HALT));

  // R2
  load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LOAD) |-> (sp == ($clog2(SLOTS)+1)'(SLOTS) && !busy));

  // R8
  sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= ($clog2(SLOTS)+1)'(SLOTS));

  // R9
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp == $past(sp)) || (sp == $past(sp) + 1'b1) || (sp + 1'b1 == $past(sp)));
endmodule

bind stk8_core stk8_core_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .fault(fault), .state(state), .sp(sp)
);

// File: tb/stk8_core_bench.sv
module stk8_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_we;
  logic [6:0]  ld_addr;
  logic [7:0]  ld_byte;
  logic        run;
  logic [4:0]  dbg_addr;
  logic [31:0] dbg_word;
  logic        busy, fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stk8_core u_stk8_core (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_byte(ld_byte),
    .run(run), .dbg_addr(dbg_addr), .dbg_word(dbg_word), .busy(busy), .fault(fault)
  );

  function automatic logic [7:0] ins(input logic [2:0] o, input logic [4:0] v);
    return {o, v};
  endfunction

  localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, NAND = 3'd2, PUSH = 3'd3,
                         POP = 3'd4, PUSHC = 3'd5, JZ = 3'd6, JA = 3'd7;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic peek(input int idx, output logic [31:0] w);
    dbg_addr = 5'(idx);
    #1;
    w = dbg_word;
  endtask

  task automatic check_word(input string req, input int idx, input logic [31:0] exp);
    logic [31:0] w;
    peek(idx, w);
    check(req, w, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_byte = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input int a, input logic [7:0] b);
    ld_we = 1'b1; ld_addr = 7'(a); ld_byte = b;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic go(input int cycles);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 fault", {31'd0, fault}, 32'd0);
    check_word("R1 data0", 0, 32'd0);
    check_word("R1 data31", 31, 32'd0);
  endtask

  task automatic t_load_mode();
    do_reset();
    put(0, ins(PUSHC, 5));
    put(1, ins(POP, 15));
    put(2, ins(PUSHC, 0));
    put(3, ins(JZ, 0));
    repeat (30) @(negedge clk);
    check("R2 idle busy", {31'd0, busy}, 32'd0);
    check_word("R2 no exec", 15, 32'd0);
    go(40);
    check("R2 running", {31'd0, busy}, 32'd1);
    check_word("R2 executed", 15, 32'd5);
  endtask

  task automatic t_alu();
    do_reset();
    put(0, ins(PUSHC, 5));  put(1, ins(PUSHC, 3));  put(2, ins(ADD, 0));  put(3, ins(POP, 0));
    put(4, ins(PUSHC, 5));  put(5, ins(PUSHC, 3));  put(6, ins(SUB, 0));  put(7, ins(POP, 1));
    put(8, ins(PUSHC, 12)); put(9, ins(PUSHC, 10)); put(10, ins(NAND, 0)); put(11, ins(POP, 2));
    put(12, ins(PUSHC, 0)); put(13, ins(JZ, 0));
    go(80);
    check_word("R3 add", 0, 32'd8);
    check_word("R3 sub top minus below", 1, 32'hFFFF_FFFE);
    check_word("R3 nand", 2, 32'hFFFF_FFF7);
    check("R3 no fault", {31'd0, fault}, 32'd0);
  endtask

  task automatic t_push_pop();
    do_reset();
    put(0, ins(PUSHC, 31)); put(1, ins(POP, 4));
    put(2, ins(PUSH, 4));   put(3, ins(PUSH, 4));
    put(4, ins(ADD, 0));    put(5, ins(POP, 5));
    put(6, ins(PUSHC, 0));  put(7, ins(JZ, 0));
    go(60);
    check_word("R5 pushc zero-extend", 4, 32'd31);
    check_word("R4 push copies data", 5, 32'd62);
    check("R4 no fault", {31'd0, fault}, 32'd0);
  endtask

  task automatic t_jz();
    do_reset();
    put(0, ins(PUSHC, 0));
    put(1, ins(JZ, 3));
    put(2, ins(PUSHC, 31));
    put(3, ins(POP, 6));
    put(4, ins(PUSHC, 1));
    put(5, ins(JZ, 2));
    put(6, ins(POP, 7));
    put(7, ins(POP, 8));
    put(8, ins(PUSHC, 0));
    put(9, ins(JZ, 0));
    go(80);
    check_word("R6 taken skips", 6, 32'd0);
    check_word("R6 not taken falls through", 7, 32'd1);
    check("R6 jz keeps top", {31'd0, fault}, 32'd0);
  endtask

  task automatic t_ja();
    do_reset();
    put(0, ins(PUSHC, 31)); put(1, ins(PUSHC, 31)); put(2, ins(NAND, 0)); put(3, ins(JA, 0));
    put(4, ins(PUSHC, 9));  put(5, ins(POP, 9));
    put(96, ins(PUSHC, 2)); put(97, ins(POP, 10));
    put(98, ins(PUSHC, 0)); put(99, ins(JZ, 0));
    go(80);
    check_word("R7 masked target reached", 10, 32'd2);
    check_word("R7 fall-through skipped", 9, 32'd0);
    check("R7 no fault", {31'd0, fault}, 32'd0);
    do_reset();
    put(0, ins(PUSHC, 3)); put(1, ins(JA, 0)); put(2, ins(PUSHC, 0)); put(3, ins(POP, 13));
    go(40);
    check("R7 ja pops then pop underflows", {31'd0, fault}, 32'd1);
    check_word("R9 no store on underflow", 13, 32'd0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 33; i++) put(i, ins(PUSHC, 1));
    put(33, ins(POP, 0));
    go(300);
    check("R8 overflow fault", {31'd0, fault}, 32'd1);
    check("R8 busy low", {31'd0, busy}, 32'd0);
    check_word("R8 data untouched", 0, 32'd0);
  endtask

  task automatic t_underflow();
    do_reset();
    put(0, ins(PUSHC, 7)); put(1, ins(POP, 3));
    put(2, ins(PUSHC, 2)); put(3, ins(ADD, 0));
    put(4, ins(POP, 3));
    go(60);
    check("R9 binary underflow", {31'd0, fault}, 32'd1);
    check_word("R9 marker kept", 3, 32'd7);
    go(40);
    check("R10 fault sticky", {31'd0, fault}, 32'd1);
    check("R10 busy stays low", {31'd0, busy}, 32'd0);
    check_word("R10 nothing executes", 3, 32'd7);
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_byte = '0; dbg_addr = '0;
    t_reset();
    t_load_mode();
    t_alu();
    t_push_pop();
    t_jz();
    t_ja();
    t_overflow();
    t_underflow();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule